// File: doc/BRIEF.md
# Lockable PWM Timer

This is a single-channel pulse-width modulator. Its register interface holds four 32-bit registers: a counter, a period, a duty and a control word. One clock drives both the register side and the counter. In each period the counter steps from zero up to the active period minus one. The output sits at the duty-phase level while the count is below the active duty, and at the inactive-phase level for the rest of the period.

Software never writes the values the waveform runs on. Each write lands in a shadow copy, and shadow values move into the active set only at a period boundary, so a period is never cut short. A lock bit in the control word freezes the active set. While the lock is set, software can rewrite period, duty and polarity without the pin noticing. One control write that clears the lock makes all three new values take effect together at the next boundary.

Top module: `pwm_lock_timer`

## Requirements
- R1: Registers are decoded from address bits [3:2]: counter at byte offset 0x00, period at 0x04, duty at 0x08, control at 0x0C. Period, duty and control read back the value last written. A counter read returns the live count. Writes to the counter are ignored.
- R2: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. When it is not running, the count is held at 0, and one cycle later the output drives control bit 4 as currently written.
- R3: While running with active period P ≥ 2, the counter counts 0..P-1 and then wraps, so the output repeats every P cycles. A period of 0 or 1 holds the count at 0.
- R4: With active duty D, the output is at the duty-phase level for min(D,P) cycles of each period. D = 0 gives a constant inactive level, and D ≥ P gives a constant duty-phase level.
- R5: Control bit 3 is the duty-phase level and bit 4 is the inactive-phase level (1 = high). 0x08 in those bits is normal polarity and 0x10 is inverted polarity.
- R6: While control bit 6 (lock) is 1, writes to period, duty and the polarity bits are stored and read back, but they do not change the waveform.
- R7: A control write that clears the lock commits the stored period, duty and polarity together at the next period boundary.
- R8: With the lock clear, a period or duty write takes effect only at the next period boundary. The period in progress runs to its full old length.
- R9: After reset all registers read 0 and the output is low.
- R10: When the channel is not running and the lock is clear, the shadow values are loaded continuously, so the first period after enable uses the latest written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register side and the counter |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W (4) | Byte address; bits [3:2] select the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench attacks the lock sequence. It rewrites period, duty and polarity under lock and checks that pulse widths do not move. A design that applied shadow values straight away would show the new widths at once. After unlock, the bench checks that the inverted high time of the new pair appears, which catches a design that commits only some of the values. Shrinking the period in mid-period must still let the count reach the old maximum. A design that loads on write would wrap early. The bench also covers the duty extremes (zero, and duty equal to the period), enable without the continuous bit, and the idle level when stopped. A wrong comparison or gating rule there would show a stray pulse or the wrong constant level.

// File: rtl/pwm_lock_pkg.sv
// Package pwm_lock_pkg
// Shared constants and types for the lockable PWM timer.
// Assumes byte addressing with 32-bit word registers.
package pwm_lock_pkg;
    // Register select values taken from address bits [3:2]
    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_PER  = 2'd1;
    localparam logic [1:0] SEL_DUTY = 2'd2;
    localparam logic [1:0] SEL_CTL  = 2'd3;

    // Control word bit positions
    localparam int CTL_EN       = 0;
    localparam int CTL_CONT     = 1;
    localparam int CTL_ACT_LVL  = 3;
    localparam int CTL_IDLE_LVL = 4;
    localparam int CTL_LOCK     = 6;

    // Output levels for the two phases of a period
    typedef struct packed {
        logic act_lvl;
        logic idle_lvl;
    } pol_t;
endpackage

// File: rtl/pwm_lock_regs.sv
// Module pwm_lock_regs
// Bus-facing register file. It holds the shadow period, duty and control
// words and decodes run, lock and polarity from the control word.
// Assumes single-cycle writes; reads are combinational; the counter
// offset is read-only and shows the live count.
module pwm_lock_regs
    import pwm_lock_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] per_sh,
    output logic [DATA_W-1:0] duty_sh,
    output pol_t              pol_sh,
    output logic              run,
    output logic              lock,
    output logic              idle_live
);
    logic [DATA_W-1:0] ctl_q;
    logic [1:0]        sel;

    assign sel = addr[3:2];

    // Store the written word into the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh  <= '0;
            duty_sh <= '0;
            ctl_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_PER:  per_sh  <= wdata;
                SEL_DUTY: duty_sh <= wdata;
                SEL_CTL:  ctl_q   <= wdata;
                default:  ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        case (sel)
            SEL_CNT:  rdata = cnt;
            SEL_PER:  rdata = per_sh;
            SEL_DUTY: rdata = duty_sh;
            default:  rdata = ctl_q;
        endcase
    end

    // Decode control fields
    always_comb begin
        run             = ctl_q[CTL_EN] & ctl_q[CTL_CONT];
        lock            = ctl_q[CTL_LOCK];
        pol_sh.act_lvl  = ctl_q[CTL_ACT_LVL];
        pol_sh.idle_lvl = ctl_q[CTL_IDLE_LVL];
        idle_live       = ctl_q[CTL_IDLE_LVL];
    end
endmodule

// File: rtl/pwm_lock_counter.sv
// Module pwm_lock_counter
// Period counter plus the active period, duty and polarity set.
// The active set loads from the shadows only when the lock is clear,
// either at a wrap or while the channel is stopped.
module pwm_lock_counter
    import pwm_lock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              lock,
    input  logic [DATA_W-1:0] per_sh,
    input  logic [DATA_W-1:0] duty_sh,
    input  pol_t              pol_sh,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] per_act,
    output logic [DATA_W-1:0] duty_act,
    output pol_t              pol_act,
    output logic              wrap
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] cnt_inc;
    logic             load;

    // Detect the last cycle of the running period
    always_comb begin
        cnt_inc = {1'b0, cnt} + EXT_W'(1);
        wrap    = run && (cnt_inc >= {1'b0, per_act});
        load    = !lock && (!run || wrap);
    end

    // Step or clear the counter
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!run || wrap) cnt <= '0;
        else                  cnt <= cnt_inc[DATA_W-1:0];
    end

    // Commit the shadows into the active set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act  <= '0;
            duty_act <= '0;
            pol_act  <= '0;
        end else if (load) begin
            per_act  <= per_sh;
            duty_act <= duty_sh;
            pol_act  <= pol_sh;
        end
    end
endmodule

// File: rtl/pwm_lock_outstage.sv
// Module pwm_lock_outstage
// Compares the count with the active duty and registers the pin level.
// When stopped, it drives the live inactive-level bit instead.
module pwm_lock_outstage
    import pwm_lock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] duty_act,
    input  pol_t              pol_act,
    input  logic              idle_live,
    output logic              pwm_out
);
    logic level;

    // Pick the phase level for the current count
    always_comb begin
        if (!run)                 level = idle_live;
        else if (cnt < duty_act)  level = pol_act.act_lvl;
        else                      level = pol_act.idle_lvl;
    end

    // Register the pin so comparator glitches never reach it
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= level;
    end
endmodule

// File: rtl/pwm_lock_timer.sv
// Module pwm_lock_timer
// Top of the lockable PWM timer. It ties the register file, the counter
// with its active set, and the output stage together.
// Assumes one clock for the bus and the counter, and a prescale of 1.
module pwm_lock_timer
    import pwm_lock_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    logic [DATA_W-1:0] per_sh, duty_sh, cnt, per_act, duty_act;
    pol_t              pol_sh, pol_act;
    logic              run, lock, idle_live, wrap;

    pwm_lock_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt), .rdata(bus_rdata),
        .per_sh(per_sh), .duty_sh(duty_sh), .pol_sh(pol_sh),
        .run(run), .lock(lock), .idle_live(idle_live)
    );

    pwm_lock_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .lock(lock),
        .per_sh(per_sh), .duty_sh(duty_sh), .pol_sh(pol_sh),
        .cnt(cnt), .per_act(per_act), .duty_act(duty_act),
        .pol_act(pol_act), .wrap(wrap)
    );

    pwm_lock_outstage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
        .duty_act(duty_act), .pol_act(pol_act), .idle_live(idle_live),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_lock_chk.sv
// Module pwm_lock_chk
// Assertion checker bound into pwm_lock_timer.
module pwm_lock_chk
    import pwm_lock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              lock,
    input logic              wrap,
    input logic              idle_live,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] per_act,
    input logic [DATA_W-1:0] duty_act,
    input pol_t              pol_act,
    input logic              pwm_out
);
    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act > 1) |-> (cnt < per_act));

    // R2
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_out == $past(idle_live)));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(per_act) && $stable(duty_act) && $stable(pol_act)));

    // R8
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(per_act) && $stable(duty_act) && $stable(pol_act)));

    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty_act == '0) |=> (pwm_out == $past(pol_act.idle_lvl)));
endmodule

bind pwm_lock_timer pwm_lock_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .lock(lock), .wrap(wrap),
    .idle_live(idle_live), .cnt(cnt), .per_act(per_act),
    .duty_act(duty_act), .pol_act(pol_act), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_lock_timer.sv
// Directed bench for pwm_lock_timer: one task per scenario.
module sim_pwm_lock_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pwm_lock_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    localparam logic [3:0] A_CNT = 4'h0, A_PER = 4'h4, A_DUTY = 4'h8, A_CTL = 4'hC;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Measure the high time and period of the output, starting at a rising edge
    task automatic measure(output int hi, output int per);
        int lo;
        int t;
        hi = 0; lo = 0; t = 0;
        @(negedge clk);
        while (pwm_out !== 1'b0 && t < 1000) begin @(negedge clk); t++; end
        while (pwm_out !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
        while (pwm_out === 1'b1 && t < 3000) begin hi++; @(negedge clk); t++; end
        while (pwm_out === 1'b0 && t < 4000) begin lo++; @(negedge clk); t++; end
        per = hi + lo;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) h++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check("R9 pwm_out after reset", pwm_out, 0);
        rd(A_PER, d);  check("R9 period after reset", d, 0);
        rd(A_DUTY, d); check("R9 duty after reset", d, 0);
        rd(A_CTL, d);  check("R9 control after reset", d, 0);
        rd(A_CNT, d);  check("R9 counter after reset", d, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(A_PER, 32'hDEAD_0010);
        wr(A_DUTY, 32'h0000_1234);
        wr(A_CTL, 32'h0000_0110);
        wr(A_CNT, 32'h0000_0055);
        rd(A_PER, d);  check("R1 period readback", d, 32'hDEAD_0010);
        rd(A_DUTY, d); check("R1 duty readback", d, 32'h0000_1234);
        rd(A_CTL, d);  check("R1 control readback", d, 32'h0000_0110);
        rd(A_CNT, d);  check("R1 counter write ignored", d, 0);
        idle(2);
        check("R2 stopped output follows bit 4", pwm_out, 1);
        wr(A_CTL, 32'h0);
        idle(2);
        check("R2 stopped output follows bit 4 low", pwm_out, 0);
    endtask

    task automatic t_normal();
        int hi, per;
        logic [31:0] a, b;
        wr(A_PER, 10); wr(A_DUTY, 3); wr(A_CTL, 32'h0B);
        idle(25);
        measure(hi, per);
        check("R4 normal high time", hi, 3);
        check("R3 normal period", per, 10);
        rd(A_CNT, a); @(negedge clk); rd(A_CNT, b);
        check("R1 live counter steps", (b == a + 1) || (b == 0 && a == 9), 1);
        check("R3 counter below period", b < 10, 1);
    endtask

    task automatic t_inverted();
        int hi, per;
        wr(A_CTL, 32'h13);
        idle(25);
        measure(hi, per);
        check("R5 inverted high time", hi, 7);
        check("R5 inverted period", per, 10);
    endtask

    task automatic t_extremes();
        int h;
        wr(A_CTL, 32'h0B);
        wr(A_PER, 8); wr(A_DUTY, 0);
        idle(25);
        count_high(40, h);
        check("R4 duty zero stays inactive", h, 0);
        wr(A_DUTY, 8);
        idle(25);
        count_high(40, h);
        check("R4 duty equal period stays active", h, 40);
        wr(A_DUTY, 500);
        idle(25);
        count_high(40, h);
        check("R4 duty above period stays active", h, 40);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        wr(A_CTL, 32'h09);
        idle(3);
        rd(A_CNT, d);
        check("R2 enable without continuous holds count", d, 0);
        check("R2 enable without continuous idle low", pwm_out, 0);
        wr(A_CTL, 32'h11);
        idle(3);
        rd(A_CNT, d);
        check("R2 disabled count zero", d, 0);
        check("R2 disabled drives idle high", pwm_out, 1);
    endtask

    task automatic t_lock();
        int hi, per;
        logic [31:0] d;
        // R10: configure while stopped, then enable
        wr(A_CTL, 32'h00);
        wr(A_PER, 10); wr(A_DUTY, 3);
        wr(A_CTL, 32'h0B);
        idle(25);
        wr(A_CTL, 32'h4B);
        wr(A_PER, 20); wr(A_DUTY, 15);
        wr(A_CTL, 32'h53);
        rd(A_PER, d); check("R6 period stored under lock", d, 20);
        idle(30);
        measure(hi, per);
        check("R6 high time frozen under lock", hi, 3);
        check("R6 period frozen under lock", per, 10);
        wr(A_CTL, 32'h13);
        idle(45);
        measure(hi, per);
        check("R7 committed inverted high time", hi, 5);
        check("R7 committed period", per, 20);
    endtask

    task automatic t_no_truncate();
        logic [31:0] d;
        int mx, t;
        wr(A_CTL, 32'h00);
        wr(A_PER, 20); wr(A_DUTY, 5);
        wr(A_CTL, 32'h0B);
        t = 0;
        rd(A_CNT, d);
        while (d != 12 && t < 100) begin @(negedge clk); rd(A_CNT, d); t++; end
        bus_wr = 1'b1; bus_addr = A_PER; bus_wdata = 5;
        @(negedge clk);
        bus_wr = 1'b0;
        mx = 0; t = 0;
        rd(A_CNT, d);
        while (d != 0 && t < 40) begin
            if (d > mx) mx = d;
            @(negedge clk); rd(A_CNT, d); t++;
        end
        check("R8 running period not cut short", mx, 19);
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); rd(A_CNT, d);
            if (d > mx) mx = d;
        end
        check("R8 new period after boundary", mx, 4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_normal();
        t_inverted();
        t_extremes();
        t_gating();
        t_lock();
        t_no_truncate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule